// File: doc/BRIEF.md
# Serial Attenuation Control Port

This block is the receiving side of a three-wire serial control link that programs per-channel volume attenuation in an audio datapath. A host holds a latch strobe low and clocks in a 16-bit control word on a shift clock, most significant bit first. It then raises the strobe to commit the word. All three wires are treated as asynchronous. They are resynchronised into the system clock domain, and their edges are detected there.

Each committed word is aimed at one of three registers: a left attenuation code, a right attenuation code, or a control register that holds a channel-link flag. A load bit in each word decides whether the new code reaches the datapath at once, or is only stored until a later word loads it. When the link flag is set, the left code drives both channels. The two active 8-bit codes are presented as outputs, where FFh means 0 dB and 00h means mute.

Top module: `atten_ctrl_port`

## Requirements
- R1: After reset both active codes are FFh, both stored codes are FFh and the link flag is 0.
- R2: A word is 16 bits, sent MSB first. Bits 10:9 are the register address (0 = left, 1 = right, 2 = unused, 3 = control), bit 8 is the load bit and bits 7:0 are the data. Bits 15:11 have no effect.
- R3: A word is committed on a rising edge of the latch strobe only if exactly 16 rising shift-clock edges occurred since the previous strobe rising edge. Otherwise it is discarded and changes nothing.
- R4: A committed address-0 word with load 1 sets the stored left code and the active left code to its data. The active right code becomes the same data when linked, and the stored right code when unlinked.
- R5: A committed address-1 word with load 1 stores its data as the right code. The active left code becomes the stored left code. The active right code becomes the stored left code when linked, and the new data when unlinked.
- R6: A committed address-0 or address-1 word with load 0 updates only the stored code. Both active codes keep their values.
- R7: A committed address-3 word sets the link flag to its data bit 2. It leaves both active codes unchanged.
- R8: A committed address-2 word has no effect on any state.
- R9: The active codes change only in the system-clock cycle that follows a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| latch_i | input | 1 | Latch strobe; its rising edge commits a word |
| sclk_i | input | 1 | Shift clock; data is sampled on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| atten_left_o | output | 8 | Active left attenuation code |
| atten_right_o | output | 8 | Active right attenuation code |

## Verification
The bench builds the block with its default parameters: a 16-bit word, 8-bit codes, the address at bits 10:9, the load flag at bit 8 and two synchroniser stages. These defaults put the exact-length check of the framer within reach of words one bit short or one bit long. With them, every decoded address (including the unused one) and the reserved upper bits can be driven. Random words mix addresses, load values and link states, so the bench reaches the load-rule combinations in which a stored code differs from an active one.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_LEFT  = 2'd0,
      REG_RIGHT = 2'd1,
      REG_SPARE = 2'd2,
      REG_CTRL  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/atten_ctrl_sync.sv
module atten_ctrl_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   input  logic [W-1:0] rst_val_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= rst_val_i;
            else         stage_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= rst_val_i;
            else         stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/atten_ctrl_framer.sv
module atten_ctrl_framer #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              latch_s_i,
   input  logic              sclk_s_i,
   input  logic              sdata_s_i,
   output logic              commit_o,
   output logic [WORD_W-1:0] word_o
);

   localparam int unsigned CNT_MAX = WORD_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic              latch_q, sclk_q;
   logic              latch_rise, sclk_rise;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [WORD_W-1:0] shift_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         latch_q <= 1'b1;
         sclk_q  <= 1'b0;
      end else begin
         latch_q <= latch_s_i;
         sclk_q  <= sclk_s_i;
      end
   end

   assign latch_rise = latch_s_i & ~latch_q;
   assign sclk_rise  = sclk_s_i & ~sclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shift_q <= '0;
      end else if (sclk_rise) begin
         shift_q <= {shift_q[WORD_W-2:0], sdata_s_i};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_cnt_q <= '0;
      end else if (latch_rise) begin
         bit_cnt_q <= '0;
      end else if (sclk_rise && (bit_cnt_q != CNT_W'(CNT_MAX))) begin
         bit_cnt_q <= bit_cnt_q + 1'b1;
      end
   end

   assign commit_o = latch_rise && (bit_cnt_q == CNT_W'(WORD_W));
   assign word_o   = shift_q;

endmodule

// File: rtl/atten_ctrl_regs.sv
module atten_ctrl_regs
   import atten_ctrl_pkg::*;
#(
   parameter int unsigned            WORD_W   = 16,
   parameter int unsigned            CODE_W   = 8,
   parameter int unsigned            ADDR_LSB = 9,
   parameter int unsigned            LOAD_BIT = 8,
   parameter int unsigned            LINK_BIT = 2,
   parameter logic [CODE_W-1:0]      RST_CODE = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              commit_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              link_o,
   output logic [CODE_W-1:0] act_left_o,
   output logic [CODE_W-1:0] act_right_o
);

   reg_sel_e          sel;
   logic              load;
   logic [CODE_W-1:0] data;
   logic [CODE_W-1:0] st_left_q, st_right_q;
   logic [CODE_W-1:0] act_left_q, act_right_q;
   logic              link_q;

   assign sel  = reg_sel_e'(word_i[ADDR_LSB +: ADDR_W]);
   assign load = word_i[LOAD_BIT];
   assign data = word_i[CODE_W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_left_q   <= RST_CODE;
         st_right_q  <= RST_CODE;
         act_left_q  <= RST_CODE;
         act_right_q <= RST_CODE;
         link_q      <= 1'b0;
      end else if (commit_i) begin
         unique case (sel)
            REG_LEFT: begin
               st_left_q <= data;
               if (load) begin
                  act_left_q  <= data;
                  act_right_q <= link_q ? data : st_right_q;
               end
            end
            REG_RIGHT: begin
               st_right_q <= data;
               if (load) begin
                  act_left_q  <= st_left_q;
                  act_right_q <= link_q ? st_left_q : data;
               end
            end
            REG_CTRL:  link_q <= data[LINK_BIT];
            default:   ;
         endcase
      end
   end

   assign link_o      = link_q;
   assign act_left_o  = act_left_q;
   assign act_right_o = act_right_q;

endmodule

// File: rtl/atten_ctrl_port.sv
module atten_ctrl_port #(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned ADDR_LSB    = 9,
   parameter int unsigned LOAD_BIT    = 8,
   parameter int unsigned LINK_BIT    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              latch_i,
   input  logic              sclk_i,
   input  logic              sdata_i,
   output logic [CODE_W-1:0] atten_left_o,
   output logic [CODE_W-1:0] atten_right_o
);

   localparam int unsigned ADDR_W = atten_ctrl_pkg::ADDR_W;

   if (ADDR_LSB + ADDR_W > WORD_W) begin : g_bad_addr
      $error("address field exceeds word width");
   end
   if (LOAD_BIT >= ADDR_LSB || LOAD_BIT < CODE_W) begin : g_bad_load
      $error("load bit must sit between data and address");
   end
   if (LINK_BIT >= CODE_W) begin : g_bad_link
      $error("link bit outside data field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages required");
   end

   logic [2:0]        pins_s;
   logic              commit_w;
   logic [WORD_W-1:0] word_w;
   logic              link_w;

   atten_ctrl_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .d_i       ({latch_i, sclk_i, sdata_i}),
      .rst_val_i (3'b100),
      .q_o       (pins_s)
   );

   atten_ctrl_framer #(
      .WORD_W (WORD_W)
   ) framer_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .latch_s_i (pins_s[2]),
      .sclk_s_i  (pins_s[1]),
      .sdata_s_i (pins_s[0]),
      .commit_o  (commit_w),
      .word_o    (word_w)
   );

   atten_ctrl_regs #(
      .WORD_W   (WORD_W),
      .CODE_W   (CODE_W),
      .ADDR_LSB (ADDR_LSB),
      .LOAD_BIT (LOAD_BIT),
      .LINK_BIT (LINK_BIT)
   ) regs_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .commit_i    (commit_w),
      .word_i      (word_w),
      .link_o      (link_w),
      .act_left_o  (atten_left_o),
      .act_right_o (atten_right_o)
   );

endmodule

// File: rtl/atten_ctrl_port_chk.sv
module atten_ctrl_port_chk #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned ADDR_LSB = 9,
   parameter int unsigned LOAD_BIT = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              commit_w,
   input logic [WORD_W-1:0] word_w,
   input logic              link_w,
   input logic [CODE_W-1:0] atten_left_o,
   input logic [CODE_W-1:0] atten_right_o
);

   logic [1:0]        addr;
   logic              load;
   logic [CODE_W-1:0] data;

   assign addr = word_w[ADDR_LSB +: 2];
   assign load = word_w[LOAD_BIT];
   assign data = word_w[CODE_W-1:0];

   assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_w |=> ($stable(atten_left_o) && $stable(atten_right_o)));

   assert_left_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_w && addr == 2'd0 && load) |=> (atten_left_o == $past(data)));

   assert_link_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_w && addr == 2'd0 && load && link_w) |=> (atten_right_o == atten_left_o));

   assert_right_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_w && addr == 2'd1 && load && !link_w) |=> (atten_right_o == $past(data)));

   assert_noload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_w && !addr[1] && !load) |=> ($stable(atten_left_o) && $stable(atten_right_o)));

   assert_ctrl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_w && addr[1]) |=> ($stable(atten_left_o) && $stable(atten_right_o)));

endmodule

bind atten_ctrl_port atten_ctrl_port_chk #(
   .WORD_W   (WORD_W),
   .CODE_W   (CODE_W),
   .ADDR_LSB (ADDR_LSB),
   .LOAD_BIT (LOAD_BIT)
) chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .commit_w      (commit_w),
   .word_w        (word_w),
   .link_w        (link_w),
   .atten_left_o  (atten_left_o),
   .atten_right_o (atten_right_o)
);

// File: tb/atten_ctrl_port_tb_top.sv
`timescale 1ns/1ps
module atten_ctrl_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       latch = 1'b1;
   logic       sclk = 1'b0;
   logic       sdata = 1'b0;
   logic [7:0] left_o, right_o;

   int n_run = 0;
   int n_fail = 0;

   logic [7:0] m_sl = 8'hFF, m_sr = 8'hFF, m_al = 8'hFF, m_ar = 8'hFF;
   logic       m_link = 1'b0;

   always #2.5 clk = ~clk;

   atten_ctrl_port dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .latch_i       (latch),
      .sclk_i        (sclk),
      .sdata_i       (sdata),
      .atten_left_o  (left_o),
      .atten_right_o (right_o)
   );

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [15:0] mk(input logic [1:0] a, input logic ld,
                                      input logic [7:0] d);
      return {5'b0, a, ld, d};
   endfunction

   task automatic model(input logic [15:0] w);
      logic [1:0] a;
      logic [7:0] d;
      a = w[10:9];
      d = w[7:0];
      case (a)
         2'd0: begin
            m_sl = d;
            if (w[8]) begin m_al = d; m_ar = m_link ? d : m_sr; end
         end
         2'd1: begin
            m_sr = d;
            if (w[8]) begin m_al = m_sl; m_ar = m_link ? m_sl : d; end
         end
         2'd3: m_link = d[2];
         default: ;
      endcase
   endtask

   task automatic send(input logic [31:0] w, input int nbits);
      latch = 1'b0;
      wait_clk(3);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdata = w[i];
         wait_clk(3);
         sclk = 1'b1;
         wait_clk(3);
         sclk = 1'b0;
      end
      wait_clk(3);
      latch = 1'b1;
      wait_clk(8);
      if (nbits == 16) model(w[15:0]);
   endtask

   task automatic check(input string req);
      n_run++;
      if (left_o !== m_al || right_o !== m_ar) begin
         n_fail++;
         $display("FAIL %s: actual L=%02h R=%02h expected L=%02h R=%02h",
                  req, left_o, right_o, m_al, m_ar);
      end
   endtask

   initial begin : watchdog
      #900000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(6);
      check("R1 reset codes FFh");

      // R1: link cleared -> left load leaves right at its stored FFh
      send(mk(2'd0, 1'b1, 8'h40), 16);
      check("R1 link clear after reset / R4 unlinked");

      // R6: store without load
      send(mk(2'd1, 1'b0, 8'h12), 16);
      check("R6 right store only");
      send(mk(2'd0, 1'b0, 8'h33), 16);
      check("R6 left store only");

      // R5: right load picks stored left
      send(mk(2'd1, 1'b1, 8'h55), 16);
      check("R5 right load unlinked");

      // R8: unused address
      send(mk(2'd2, 1'b1, 8'h00), 16);
      check("R8 spare address ignored");

      // R7: link on, no output change
      send(mk(2'd3, 1'b1, 8'h04), 16);
      check("R7 link set leaves codes");
      send(mk(2'd0, 1'b1, 8'h00), 16);
      check("R4 linked left load mute");
      send(mk(2'd1, 1'b1, 8'h9A), 16);
      check("R5 linked right load uses left");

      // R2: reserved upper bits ignored
      send({16'h0, 5'b11111, 2'd0, 1'b1, 8'h7E}, 16);
      check("R2 reserved bits ignored");

      // R3: short and long words discarded
      send({16'h0, mk(2'd0, 1'b1, 8'h01)}, 15);
      check("R3 short word discarded");
      send({15'h0, 1'b0, mk(2'd1, 1'b1, 8'h02)}, 17);
      check("R3 long word discarded");

      send(mk(2'd3, 1'b1, 8'h00), 16);
      send(mk(2'd0, 1'b1, 8'hFE), 16);
      check("R4 unlinked after clear");

      for (int k = 0; k < 40; k++) begin
         logic [15:0] w;
         int          nb;
         w  = 16'($urandom());
         nb = ($urandom_range(0, 9) == 0) ? 15 : 16;
         send({16'h0, w}, nb);
         check("R2 R3 R4 R5 R6 R7 R8 random word");
      end

      // R9: outputs stay put with no commit
      wait_clk(20);
      check("R9 idle hold");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule